// File: doc/BRIEF.md
# Dual-Source Core Clock Handover Controller

This block holds a 32-bit configuration word that sets up two clock generators. It decides which of the two drives the core clock, and it moves the core clock from one generator to the other on a software request. No reset is needed for the move. Machine state is kept, and no relock wait is added.

The first generator takes its multiplier and range from one of two places. It can follow external strap pins, or it can follow fields of the configuration word. The second generator always follows its own register fields.

After a select request, the handover follows a fixed three-step sequence in the bus clock domain. First, both gate requests are dropped. Next, only the target's gate request is raised. Finally, the active-source status is updated. Each source clock has its own two-flop synchronizer and a falling-edge gate, so the outgoing clock is stopped before the incoming clock starts.

A request toward a generator that is unlocked, or whose multiplier encodes "off", waits until that generator becomes ready.

Top module: `dpll_switch`

## Requirements
- R1: After hard reset, bits 7 to 31 of the configuration word read zero. The core clock source is generator 0, generator 1 is off (`pll1_en` low) and its range output is 00 (medium).
- R2: Bits [4:0] of the read value always show the live strap multiplier and bits [6:5] show the live strap range. Writes to these bits have no effect.
- R3: Bit 8 (source-select for generator 0): when 0, `pll0_mult`/`pll0_range` follow the straps. When 1, they follow register bits [13:9] (multiplier) and [15:14] (range).
- R4: `pll1_mult`/`pll1_range` always follow register bits [20:16] and [22:21]. The straps have no effect on them.
- R5: A multiplier of all zeros means off: `pllN_en` is low exactly when the effective multiplier of that generator is zero. Range codes pass through unchanged: 00 medium, 01 low, 10 high.
- R6: Bit 7 requests the core source (0 = generator 0, 1 = generator 1). When the target is ready, `active_src` and read bit 31 take the new value on the third bus clock edge after the edge that samples the write. Neither changes at any other time.
- R7: A request toward a generator whose lock input is low, or whose effective multiplier is zero, stays pending. The handover starts on the first edge that sees the target ready, and the status changes two edges after that.
- R8: The two source gates are never open together. `core_clk` carries no high pulse shorter than a half period of its source. Once a handover has settled, `core_clk` runs at the period of the selected source.
- R9: Bits [30:23] read zero regardless of what is written. Bit 31 is read-only status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock for the register port and sequencer |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read value of the configuration word |
| strap_mult | input | 5 | External multiplier straps for generator 0 |
| strap_range | input | 2 | External range straps for generator 0 |
| pll0_lock | input | 1 | Lock flag of generator 0 |
| pll1_lock | input | 1 | Lock flag of generator 1 |
| pll0_clk | input | 1 | Output clock of generator 0 |
| pll1_clk | input | 1 | Output clock of generator 1 |
| pll0_mult | output | 5 | Effective multiplier driven to generator 0 |
| pll0_range | output | 2 | Effective range driven to generator 0 |
| pll0_en | output | 1 | Generator 0 enable (multiplier non-zero) |
| pll1_mult | output | 5 | Multiplier driven to generator 1 |
| pll1_range | output | 2 | Range driven to generator 1 |
| pll1_en | output | 1 | Generator 1 enable (multiplier non-zero) |
| core_clk | output | 1 | Glitch-free selected core clock |
| active_src | output | 1 | Source currently driving the core clock |

## Verification
The bench builds the block with its default widths: a 5-bit multiplier, a 2-bit range and two synchronizer stages. Against a 10 ns bus clock, it drives the sources at 2.0 ns and 1.6 ns periods. With these values, the 7-bit strap field and every register field can be reached with distinct patterns. Each gate settles well inside one bus cycle, so the exact three-edge handover timing and the non-overlap of gates can both be observed. The different source periods let the bench tell which generator `core_clk` follows after each handover, including handovers held back by a missing lock or by a zero multiplier.

// File: rtl/dpll_sw_pkg.sv
`timescale 1ns/1ps
package dpll_sw_pkg;
  localparam int unsigned MULT_W   = 5;
  localparam int unsigned RANGE_W  = 2;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned STRAP_W  = MULT_W + RANGE_W;
  localparam int unsigned SEL_BIT  = STRAP_W;
  localparam int unsigned SRC_BIT  = STRAP_W + 1;
  localparam int unsigned M0_LO    = STRAP_W + 2;
  localparam int unsigned R0_LO    = M0_LO + MULT_W;
  localparam int unsigned M1_LO    = R0_LO + RANGE_W;
  localparam int unsigned R1_LO    = M1_LO + MULT_W;
  localparam int unsigned RSV_LO   = R1_LO + RANGE_W;
  localparam int unsigned STAT_BIT = REG_W - 1;

  typedef struct packed {
    logic [MULT_W-1:0]  mult;
    logic [RANGE_W-1:0] rng;
  } pll_ctl_t;

  typedef enum logic [1:0] {SW_IDLE, SW_DROP, SW_RAISE} sw_state_e;

  function automatic logic pll_is_on(input pll_ctl_t c);
    return |c.mult;
  endfunction

  function automatic logic [1:0] src_onehot(input logic s);
    return s ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/dpll_sw_cfg.sv
`timescale 1ns/1ps
module dpll_sw_cfg
  import dpll_sw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wdata,
  input  logic [MULT_W-1:0]    strap_mult,
  input  logic [RANGE_W-1:0]   strap_rng,
  input  logic                 status_in,
  output logic [REG_W-1:0]     rdata,
  output logic                 sel_req,
  output pll_ctl_t             ctl0,
  output pll_ctl_t             ctl1
);
  logic     sel_q, int_q;
  pll_ctl_t reg0_q, reg1_q;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata[STRAP_W-1:0], wdata[REG_W-1:RSV_LO]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      int_q  <= 1'b0;
      reg0_q <= '0;
      reg1_q <= '0;
    end else if (wr_en) begin
      sel_q       <= wdata[SEL_BIT];
      int_q       <= wdata[SRC_BIT];
      reg0_q.mult <= wdata[M0_LO +: MULT_W];
      reg0_q.rng  <= wdata[R0_LO +: RANGE_W];
      reg1_q.mult <= wdata[M1_LO +: MULT_W];
      reg1_q.rng  <= wdata[R1_LO +: RANGE_W];
    end
  end

  assign sel_req = sel_q;
  assign ctl0    = int_q ? reg0_q : '{mult: strap_mult, rng: strap_rng};
  assign ctl1    = reg1_q;

  always_comb begin
    rdata                      = '0;
    rdata[0 +: MULT_W]         = strap_mult;
    rdata[MULT_W +: RANGE_W]   = strap_rng;
    rdata[SEL_BIT]             = sel_q;
    rdata[SRC_BIT]             = int_q;
    rdata[M0_LO +: MULT_W]     = reg0_q.mult;
    rdata[R0_LO +: RANGE_W]    = reg0_q.rng;
    rdata[M1_LO +: MULT_W]     = reg1_q.mult;
    rdata[R1_LO +: RANGE_W]    = reg1_q.rng;
    rdata[STAT_BIT]            = status_in;
  end

  // R3
  wr_mult0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> reg0_q.mult == $past(wdata[M0_LO +: MULT_W]));
  // R4
  wr_mult1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> reg1_q.mult == $past(wdata[M1_LO +: MULT_W]));
endmodule

// File: rtl/dpll_sw_seq.sv
`timescale 1ns/1ps
module dpll_sw_seq
  import dpll_sw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_req,
  input  logic [1:0] ready,
  output logic [1:0] en_req,
  output logic       active_src
);
  sw_state_e  st_q;
  logic       cur_q, tgt_q;
  logic [1:0] en_q;
  logic       want_switch;
  logic       target_blocked;

  assign want_switch    = (sel_req != cur_q) && ready[sel_req];
  assign target_blocked = (sel_req != cur_q) && !ready[sel_req];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_IDLE;
      cur_q <= 1'b0;
      tgt_q <= 1'b0;
      en_q  <= 2'b01;
    end else begin
      case (st_q)
        SW_IDLE: if (want_switch) begin
          st_q  <= SW_DROP;
          tgt_q <= sel_req;
          en_q  <= 2'b00;
        end
        SW_DROP: begin
          st_q <= SW_RAISE;
          en_q <= src_onehot(tgt_q);
        end
        SW_RAISE: begin
          st_q  <= SW_IDLE;
          cur_q <= tgt_q;
        end
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  assign en_req     = en_q;
  assign active_src = cur_q;

  // R6
  status_after_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> $past(st_q) == SW_RAISE);
  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SW_IDLE && target_blocked) |=> (st_q == SW_IDLE && $stable(cur_q)));
  // R8
  drop_before_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == SW_RAISE |-> ($past(en_q) == 2'b00 && $onehot(en_q)));
endmodule

// File: rtl/dpll_sw_gate.sv
`timescale 1ns/1ps
module dpll_sw_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en_req,
  output logic gate_on,
  output logic clk_out
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_req};
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b0;
    else        gate_on <= sync_q[SYNC_STAGES-1];
  end

  assign clk_out = src_clk & gate_on;
endmodule

// File: rtl/dpll_switch.sv
`timescale 1ns/1ps
module dpll_switch
  import dpll_sw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic [MULT_W-1:0]  strap_mult,
  input  logic [RANGE_W-1:0] strap_range,
  input  logic               pll0_lock,
  input  logic               pll1_lock,
  input  logic               pll0_clk,
  input  logic               pll1_clk,
  output logic [MULT_W-1:0]  pll0_mult,
  output logic [RANGE_W-1:0] pll0_range,
  output logic               pll0_en,
  output logic [MULT_W-1:0]  pll1_mult,
  output logic [RANGE_W-1:0] pll1_range,
  output logic               pll1_en,
  output logic               core_clk,
  output logic               active_src
);
  pll_ctl_t   ctl0, ctl1;
  logic       sel_req;
  logic [1:0] ready, en_req, gate_on, gclk, src_clk;

  dpll_sw_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
    .strap_mult(strap_mult), .strap_rng(strap_range), .status_in(active_src),
    .rdata(cfg_rdata), .sel_req(sel_req), .ctl0(ctl0), .ctl1(ctl1)
  );

  assign ready = {pll1_lock & pll_is_on(ctl1), pll0_lock & pll_is_on(ctl0)};

  dpll_sw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .ready(ready),
    .en_req(en_req), .active_src(active_src)
  );

  assign src_clk = {pll1_clk, pll0_clk};

  for (genvar g = 0; g < 2; g++) begin : g_gate
    dpll_sw_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .src_clk(src_clk[g]), .rst_n(rst_n), .en_req(en_req[g]),
      .gate_on(gate_on[g]), .clk_out(gclk[g])
    );
  end

  assign core_clk   = |gclk;
  assign pll0_mult  = ctl0.mult;
  assign pll0_range = ctl0.rng;
  assign pll0_en    = pll_is_on(ctl0);
  assign pll1_mult  = ctl1.mult;
  assign pll1_range = ctl1.rng;
  assign pll1_en    = pll_is_on(ctl1);

  // R8
  gates_excl0_chk: assert property (@(posedge pll0_clk) disable iff (!rst_n)
    $onehot0(gate_on));
  // R8
  gates_excl1_chk: assert property (@(posedge pll1_clk) disable iff (!rst_n)
    $onehot0(gate_on));
endmodule

// File: tb/dpll_switch_bench.sv
`timescale 1ns/1ps
module dpll_switch_bench;
  logic        clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [4:0]  strap_mult = 5'h0A, pll0_mult, pll1_mult;
  logic [1:0]  strap_range = 2'b10, pll0_range, pll1_range;
  logic        pll0_lock = 1'b1, pll1_lock = 1'b0;
  logic        pll0_clk = 1'b0, pll1_clk = 1'b0;
  logic        pll0_en, pll1_en, core_clk, active_src;

  int n_cmp = 0, n_bad = 0;
  bit run_cmp = 0;

  always #5   clk = ~clk;
  always #1.0 pll0_clk = ~pll0_clk;
  always #0.8 pll1_clk = ~pll1_clk;

  dpll_switch u_dpll_switch (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .strap_mult(strap_mult), .strap_range(strap_range),
    .pll0_lock(pll0_lock), .pll1_lock(pll1_lock), .pll0_clk(pll0_clk),
    .pll1_clk(pll1_clk), .pll0_mult(pll0_mult), .pll0_range(pll0_range),
    .pll0_en(pll0_en), .pll1_mult(pll1_mult), .pll1_range(pll1_range),
    .pll1_en(pll1_en), .core_clk(core_clk), .active_src(active_src)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_sel, m_int, m_m0, m_r0, m_m1, m_r1, m_cur, m_tgt, m_cnt;

  function automatic int eff_m0();
    return m_int ? m_m0 : int'(strap_mult);
  endfunction
  function automatic int eff_r0();
    return m_int ? m_r0 : int'(strap_range);
  endfunction
  function automatic bit src_ready(input int s);
    if (s == 0) return pll0_lock && eff_m0() != 0;
    return pll1_lock && m_m1 != 0;
  endfunction
  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = 32'(strap_mult) | (32'(strap_range) << 5) | (32'(m_sel) << 7)
      | (32'(m_int) << 8) | (32'(m_m0) << 9) | (32'(m_r0) << 14)
      | (32'(m_m1) << 16) | (32'(m_r1) << 21) | (32'(m_cur) << 31);
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_int = 0; m_m0 = 0; m_r0 = 0; m_m1 = 0; m_r1 = 0;
      m_cur = 0; m_tgt = 0; m_cnt = 0;
    end else begin
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_cur = m_tgt;
      end else if (m_sel != m_cur && src_ready(m_sel)) begin
        m_tgt = m_sel;
        m_cnt = 2;
      end
      if (cfg_wr) begin
        m_sel = int'(cfg_wdata[7]);
        m_int = int'(cfg_wdata[8]);
        m_m0  = int'(cfg_wdata[13:9]);
        m_r0  = int'(cfg_wdata[15:14]);
        m_m1  = int'(cfg_wdata[20:16]);
        m_r1  = int'(cfg_wdata[22:21]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R2 R9 readback", cfg_rdata, exp_word());
      chk("R3 pll0_mult", 32'(pll0_mult), 32'(eff_m0()));
      chk("R3 pll0_range", 32'(pll0_range), 32'(eff_r0()));
      chk("R5 pll0_en", 32'(pll0_en), 32'(eff_m0() != 0));
      chk("R4 pll1_mult", 32'(pll1_mult), 32'(m_m1));
      chk("R4 pll1_range", 32'(pll1_range), 32'(m_r1));
      chk("R5 pll1_en", 32'(pll1_en), 32'(m_m1 != 0));
      chk("R6 R7 active_src", 32'(active_src), 32'(m_cur));
    end
  end

  // ---------------- core clock observation ----------------
  realtime t_rise = 0, t_last = 0, per = 0;
  bit      clk_seen = 0;
  int      runts = 0;
  always @(posedge core_clk) begin
    if (clk_seen) per = $realtime - t_last;
    t_last = $realtime; t_rise = $realtime; clk_seen = 1;
  end
  always @(negedge core_clk) if (clk_seen && ($realtime - t_rise) < 0.75) runts++;

  task automatic chk_period(input string tag, input realtime exp_p);
    n_cmp++;
    if (per < exp_p - 0.05 || per > exp_p + 0.05) begin
      n_bad++;
      $display("FAIL %s core period actual=%0.3f expected=%0.3f", tag, per, exp_p);
    end
  endtask

  task automatic bus_write(input logic [31:0] d);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #22;
    // R1: reset state
    chk("R1 writable bits zero", cfg_rdata & 32'hFFFF_FF80, 32'h0);
    chk("R1 active source", 32'(active_src), 32'h0);
    chk("R1 pll1 off", 32'(pll1_en), 32'h0);
    chk("R1 pll1 medium range", 32'(pll1_range), 32'h0);
    #5 rst_n = 1'b1;
    run_cmp = 1;
    idle(4);
    chk_period("R8 pll0 after reset", 2.0);
    // R2: live straps
    strap_mult = 5'h13; strap_range = 2'b01;
    idle(2);
    // R2 R9: writes into read-only and reserved bits ignored
    bus_write(32'h7F80_007F);
    idle(2);
    bus_write(32'h0);
    // R3: generator 0 from register fields
    bus_write((32'h1 << 8) | (32'h07 << 9) | (32'h1 << 14));
    idle(3);
    strap_mult = 5'h05;
    idle(2);
    bus_write(32'h0);
    idle(2);
    // R4 R7: select generator 1 while it is unlocked
    bus_write((32'h1 << 7) | (32'h0C << 16) | (32'h2 << 21));
    strap_mult = 5'h1F;
    idle(6);
    chk("R7 still on pll0", 32'(active_src), 32'h0);
    pll1_lock = 1'b1;
    idle(6);
    chk_period("R8 follows pll1", 1.6);
    // R6: back to generator 0
    bus_write(32'h0 | (32'h0C << 16));
    idle(6);
    chk_period("R8 back on pll0", 2.0);
    // R5 R7: generator 1 locked but multiplier zero
    bus_write(32'h1 << 7);
    idle(5);
    chk("R5 zero mult pending", 32'(active_src), 32'h0);
    bus_write((32'h1 << 7) | (32'h03 << 16));
    idle(6);
    // R5: straps zero makes generator 0 off; return request waits
    strap_mult = 5'h00;
    bus_write(32'h03 << 16);
    idle(5);
    chk("R5 pll0 off pending", 32'(active_src), 32'h1);
    strap_mult = 5'h09;
    idle(6);
    chk_period("R8 final pll0", 2.0);
    n_cmp++;
    if (runts != 0) begin
      n_bad++;
      $display("FAIL R8 runt pulses actual=%0d expected=0", runts);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule